// File: doc/BRIEF.md
# Variable-Length Serial Word Delay

This block delays a serial bit stream by exactly one word time and by exactly two word times. The word length can be set anywhere from 16 to 32 bits. The delay storage is a small array of two-bit locations rather than a long shift register. A half-rate phase flip-flop splits every pair of bit clocks into a fill cycle and a read/write cycle. On the read/write cycle the old pair at the current address is captured into a holding register and the new pair is stored in its place. A 2:1 selector driven by the same phase then shifts the held pair back out one bit per clock. When the word length is odd, a single flip-flop ahead of the array supplies the extra bit time.

A downstream word-level searcher uses the block to see the current word and the two words before it side by side. It feeds one serial stream and a 5-bit length code, and reads two delayed taps and a strobe that marks the last bit of every word. The delay stage is generated once per tap, and the stages are chained. All stages share one controller, which holds the address counter, its terminal-count comparator, the phase flip-flop and the word-bit counter.

Top module: `vdl_top`

## Requirements
- R1: During the first cycle after reset is released, both taps and the word strobe are 0. Tap 0 stays 0 for the first L cycles and tap 1 stays 0 for the first 2L cycles, where L is the active word length.
- R2: For an even word length L, tap 0 in cycle c equals the serial input of cycle c-L. Cycle 0 is the first cycle after reset release.
- R3: For an odd word length L, tap 0 in cycle c equals the serial input of cycle c-L.
- R4: Tap 1 in cycle c equals the serial input of cycle c-2L.
- R5: A length code of 16 to 31 selects that many bits per word. A code of 1 to 15 selects 16 bits.
- R6: The word strobe is 1 exactly in the cycles c with c mod L = L-1, counted from reset release. It is 0 in every other cycle.
- R7: A new length code is applied only at the end of the word in progress, that is, on the clock edge that closes a strobe cycle. The strobe spacing and the tap delay of the current word keep the old length, and later words use the new length.
- R8: A length code of 0 selects 32 bits per word. At every length the storage address stays within locations 0 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high; loads the length code |
| serIn | input | 1 | Serial data, one bit per clock |
| lenCode | input | 5 | Word length code (0 = 32, 1..15 = 16, 16..31 = itself) |
| tapOut | output | 2 | Bit 0: delayed one word; bit 1: delayed two words |
| wordStrobe | output | 1 | High during the last bit cycle of each word |

## Verification
The hardest case to reach from the ports is a length code that changes in the middle of a word. The address counter, the word counter and the odd stage must then all move to the new length at one edge, and the old address may already lie beyond the new terminal count. The stimulus changes the code partway through a 20-bit word to an odd 27-bit length. It checks that the strobe still closes the old word at bit 20 and is spaced at 27 after that. Once the array has been rewritten, it checks both taps against the new delay. Sweeps over every length from 16 to 32 with pseudo-random data cover both settings of the odd stage and every terminal count.

// File: rtl/vdl_pkg.sv
package vdl_pkg;
  localparam int VDL_MIN_LEN = 16;
  localparam int VDL_MAX_LEN = 32;
  localparam int VDL_CODE_W  = 5;
  localparam int VDL_LEN_W   = $clog2(VDL_MAX_LEN + 1);
  localparam int VDL_DEPTH   = VDL_MAX_LEN / 2;
  localparam int VDL_ADDR_W  = $clog2(VDL_DEPTH);

  // strobes from the controller to every delay stage
  typedef struct packed {
    logic                  phase;   // 0: fill cycle, 1: read/write cycle
    logic                  wrEn;    // store pair / capture old pair
    logic [VDL_ADDR_W-1:0] addr;    // shared location address
    logic                  oddSel;  // insert the one-bit odd stage
  } vdl_strb_t;
endpackage

// File: rtl/vdl_ctrl.sv
module vdl_ctrl
  import vdl_pkg::*;
#(
  parameter int MIN_LEN = VDL_MIN_LEN,
  parameter int MAX_LEN = VDL_MAX_LEN,
  parameter int CODE_W  = VDL_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] lenCode,
  output vdl_strb_t         strb,
  output logic              wordStrobe
);
  localparam int LEN_W  = VDL_LEN_W;
  localparam int ADDR_W = VDL_ADDR_W;
  localparam int DEPTH  = VDL_DEPTH;

  logic              phase;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  bitCnt;
  logic [LEN_W-1:0]  activeLen;
  logic [LEN_W-1:0]  codedLen;
  logic [LEN_W-1:0]  lastAddr;
  logic              addrTerm;
  logic              wordEnd;

  // code decode: zero means the longest word, short codes clamp upward
  always_comb begin
    if (lenCode == '0)
      codedLen = LEN_W'(MAX_LEN);
    else if (int'(lenCode) < MIN_LEN)
      codedLen = LEN_W'(MIN_LEN);
    else
      codedLen = LEN_W'(lenCode);
  end

  // pair and holding registers add one pair time, so one location fewer
  assign lastAddr = LEN_W'({1'b0, activeLen[LEN_W-1:1]}) - LEN_W'(2);
  assign addrTerm = (LEN_W'(addr) >= lastAddr);
  assign wordEnd  = (bitCnt == LEN_W'(activeLen - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      addr      <= '0;
      bitCnt    <= '0;
      activeLen <= codedLen;
    end else begin
      phase <= ~phase;
      if (phase) addr <= addrTerm ? '0 : ADDR_W'(addr + 1'b1);
      if (wordEnd) begin
        bitCnt    <= '0;
        activeLen <= codedLen;
      end else begin
        bitCnt <= LEN_W'(bitCnt + 1'b1);
      end
    end
  end

  assign strb.phase  = phase;
  assign strb.wrEn   = phase;
  assign strb.addr   = addr;
  assign strb.oddSel = activeLen[0];
  assign wordStrobe  = wordEnd;

  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    LEN_W'(addr) <= LEN_W'(DEPTH - 2)); // R8
  AST_ADDR_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable(addr)); // R2
  AST_LEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !wordStrobe |=> $stable(activeLen)); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wordStrobe |=> !wordStrobe); // R6
endmodule

// File: rtl/vdl_stage.sv
module vdl_stage
  import vdl_pkg::*;
#(
  parameter int DEPTH = VDL_DEPTH
) (
  input  logic      clk,
  input  logic      rst,
  input  vdl_strb_t strb,
  input  logic      inBit,
  output logic      outBit
);
  logic       oddReg;
  logic       stageBit;
  logic       loReg;
  logic [1:0] holdReg;
  logic [1:0] mem [DEPTH];

  assign stageBit = strb.oddSel ? oddReg : inBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      oddReg  <= 1'b0;
      loReg   <= 1'b0;
      holdReg <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      oddReg <= inBit;
      if (!strb.phase) loReg <= stageBit;
      if (strb.wrEn) begin
        holdReg         <= mem[strb.addr];
        mem[strb.addr]  <= {stageBit, loReg};
      end
    end
  end

  // older bit of the pair leaves first
  assign outBit = strb.phase ? holdReg[1] : holdReg[0];

  AST_TAP_ZERO_AT_START: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outBit); // R1
  AST_HOLD_WRITE_PHASE: assert property (@(posedge clk) disable iff (rst)
    !strb.wrEn |=> $stable(holdReg)); // R2
endmodule

// File: rtl/vdl_datapath.sv
module vdl_datapath
  import vdl_pkg::*;
#(
  parameter int NUM_TAPS = 2,
  parameter int DEPTH    = VDL_DEPTH
) (
  input  logic                clk,
  input  logic                rst,
  input  vdl_strb_t           strb,
  input  logic                serIn,
  output logic [NUM_TAPS-1:0] tapOut
);
  logic [NUM_TAPS:0] chain;

  assign chain[0] = serIn;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    vdl_stage #(.DEPTH(DEPTH)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .strb   (strb),
      .inBit  (chain[g]),
      .outBit (chain[g+1])
    );
    assign tapOut[g] = chain[g+1];
  end
endmodule

// File: rtl/vdl_top.sv
module vdl_top
  import vdl_pkg::*;
#(
  parameter int NUM_TAPS = 2,
  parameter int CODE_W   = VDL_CODE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serIn,
  input  logic [CODE_W-1:0]   lenCode,
  output logic [NUM_TAPS-1:0] tapOut,
  output logic                wordStrobe
);
  vdl_strb_t strb;

  vdl_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .lenCode    (lenCode),
    .strb       (strb),
    .wordStrobe (wordStrobe)
  );

  vdl_datapath #(.NUM_TAPS(NUM_TAPS), .DEPTH(VDL_DEPTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .serIn  (serIn),
    .tapOut (tapOut)
  );
endmodule

// File: tb/test_vdl_top.sv
`timescale 1ns/1ps
module test_vdl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serIn = 1'b0;
  logic [4:0] lenCode = 5'd16;
  logic [1:0] tapOut;
  logic       wordStrobe;
  int         total = 0;
  int         bad = 0;
  bit         hist [0:511];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  vdl_top i_vdl_top (
    .clk(clk), .rst(rst), .serIn(serIn), .lenCode(lenCode),
    .tapOut(tapOut), .wordStrobe(wordStrobe)
  );

  task automatic chk(input string req, input string what, input int cyc,
                     input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%b expected=%b", req, what, cyc, act, exp);
    end
  endtask

  function automatic bit histAt(input int idx);
    return (idx < 0) ? 1'b0 : hist[idx];
  endfunction

  task automatic fillHist(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hist[i] = lfsr[0];
    end
  endtask

  // leaves the bench inside cycle 0 (first cycle after reset release)
  task automatic doReset(input logic [4:0] code);
    lenCode = code;
    serIn   = 1'b0;
    rst     = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic sweep(input logic [4:0] code, input int len, input string lenReq);
    int n;
    string dReq;
    n = 4 * len + 8;
    fillHist(n);
    doReset(code);
    for (int c = 0; c < n; c++) begin
      if (c == 0) chk("R1", "strobe at start", c, wordStrobe, 1'b0);
      dReq = (c < len) ? "R1" : ((len % 2) == 1 ? "R3" : "R2");
      chk(dReq, "tap0", c, tapOut[0], histAt(c - len));
      chk((c < 2 * len) ? "R1" : "R4", "tap1", c, tapOut[1], histAt(c - 2 * len));
      chk("R6", "strobe", c, wordStrobe, (c % len) == len - 1);
      if (c == len) chk(lenReq, "length via tap0", c, tapOut[0], histAt(0));
      serIn = hist[c];
      @(posedge clk);
      #1;
    end
  endtask

  task automatic changeTest();
    int n;
    logic expS;
    n = 300;
    fillHist(n);
    doReset(5'd20);
    for (int c = 0; c < n; c++) begin
      if (c == 30) lenCode = 5'd27;
      expS = (c < 40) ? ((c % 20) == 19) : (((c - 40) % 27) == 26);
      chk("R7", "strobe across change", c, wordStrobe, expS);
      if (c < 40) begin
        chk("R7", "tap0 old length", c, tapOut[0], histAt(c - 20));
        chk("R7", "tap1 old length", c, tapOut[1], histAt(c - 40));
      end else if (c >= 202) begin
        chk("R7", "tap0 new length", c, tapOut[0], histAt(c - 27));
        chk("R4", "tap1 new length", c, tapOut[1], histAt(c - 54));
      end
      serIn = hist[c];
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    for (int code = 16; code < 32; code++)
      sweep(5'(code), code, "R5");
    sweep(5'd0, 32, "R8");   // code 0 selects 32 bits
    sweep(5'd5, 16, "R5");   // short code clamps to 16
    sweep(5'd1, 16, "R5");
    changeTest();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule